// File: doc/BRIEF.md
# Store Buffer with Read Forwarding

This block sits between a write-through cache and a slower memory. Each processor store that updates the cache is also pushed into a small queue. A memory-side port drains the queue one entry at a time, in arrival order, through a valid/ready write handshake. The processor stalls only when every slot is taken and no entry leaves in that cycle, so short bursts of stores are absorbed without delay.

A read miss on its way to memory must not return data that a queued store has already replaced. The block compares the read address against every occupied slot in parallel. If the youngest matching store wrote the whole word, its data is returned in the same cycle and memory is not touched. If the youngest match wrote only some bytes, the read waits until no queued entry matches. If nothing matches, the read goes straight to memory without waiting for the queue to drain. A build-time option turns forwarding off: every read is then held until the queue is empty.

Top module: `stbuf_fwd`

## Requirements
- R1: After reset the queue is empty. `empty`=1, `full`=0, `mw_valid`=0, and with no read request `rd_done`=0 and `mr_valid`=0.
- R2: Accepted stores leave on the memory write port in arrival order, carrying their address, data and byte enables. `mw_valid` is 1 exactly when the queue holds an entry. The head stays unchanged until `mw_ready` is seen.
- R3: `full` is 1 when all DEPTH slots hold entries, and `empty` is 1 when none do. `cpu_stall` = `st_valid` AND `full` AND NOT `mw_ready`. A store is accepted exactly when it does not stall.
- R4: On a full queue, a store and a drain in the same cycle are both accepted, and the queue stays full.
- R5: Forward mode: if the youngest entry whose address equals `rd_addr` has all byte enables set (`st_be` bit i covers data bits 8i+7..8i), then in that same cycle `rd_done`=1, `rd_from_buf`=1, `rd_data` equals that entry's data, and `mr_valid`=0.
- R6: When several entries hold the read address, the data of the most recently accepted one is returned.
- R7: Forward mode: if no entry holds the read address, `mr_valid`=1 with `mr_addr`=`rd_addr` in that cycle, whatever the occupancy. `rd_done` follows `mr_ready`, and `rd_data` equals `mr_data`.
- R8: Forward mode: if the youngest matching entry has any byte enable clear, `rd_done`=0 and `mr_valid`=0 until no entry matches.
- R9: Drain mode (DRAIN_ALL=1): `mr_valid` is 1 only when a read is requested and the queue is empty. Data is never returned from the queue.
- R10: Every completed read returns the memory word with all still-queued stores to that address applied in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| st_valid | input | 1 | Processor store request |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data |
| st_be | input | DW/8 | Store byte enables |
| cpu_stall | output | 1 | Store not accepted this cycle |
| full | output | 1 | All slots occupied |
| empty | output | 1 | No slot occupied |
| mw_valid | output | 1 | Memory write request (queue head) |
| mw_addr | output | AW | Memory write address |
| mw_data | output | DW | Memory write data |
| mw_be | output | DW/8 | Memory write byte enables |
| mw_ready | input | 1 | Memory accepts the write |
| rd_valid | input | 1 | Read miss request, held until done |
| rd_addr | input | AW | Read word address |
| rd_done | output | 1 | Read completes this cycle |
| rd_from_buf | output | 1 | Read data comes from the queue |
| rd_data | output | DW | Read result |
| mr_valid | output | 1 | Memory read request |
| mr_addr | output | AW | Memory read address |
| mr_ready | input | 1 | Memory read data valid this cycle |
| mr_data | input | DW | Memory read data |

## Verification
Assertions check the queue limits and the read routing on every cycle. The queue never takes a store when full unless a drain happens in the same cycle, and never drains when empty. A stalled head stays stable. A forwarded read never also starts a memory read. A partial match blocks the read, and in drain mode a memory read is issued only on an empty queue. Whether the returned data is correct in value can only be shown by the bench's scenarios: drain order, the youngest-match choice, and the coherent merge of queued bytes over memory. The bench checks these against its own queue and memory model.

// File: rtl/stbuf_pkg.sv
package stbuf_pkg;

   typedef enum logic [1:0] {
      RT_IDLE = 2'd0,
      RT_FWD  = 2'd1,
      RT_MEM  = 2'd2,
      RT_HOLD = 2'd3
   } rd_route_e;

endpackage

// File: rtl/stbuf_queue.sv
module stbuf_queue #(
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int DEPTH = 4,
   localparam int BW   = DW / 8,
   localparam int PW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [AW-1:0] push_addr,
   input  logic [DW-1:0] push_data,
   input  logic [BW-1:0] push_be,
   input  logic          pop,
   output logic [AW-1:0] ent_addr [DEPTH],
   output logic [DW-1:0] ent_data [DEPTH],
   output logic [BW-1:0] ent_be   [DEPTH],
   output logic [PW-1:0] head_ptr,
   output logic [CW-1:0] count,
   output logic          full,
   output logic          empty
);

   logic [PW-1:0] tail_ptr;

   assign full  = (count == CW'(DEPTH));
   assign empty = (count == '0);

   always_ff @(posedge clk) begin
      if (push) begin
         ent_addr[tail_ptr] <= push_addr;
         ent_data[tail_ptr] <= push_data;
         ent_be[tail_ptr]   <= push_be;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_ptr <= '0;
         tail_ptr <= '0;
         count    <= '0;
      end else begin
         if (push) tail_ptr <= tail_ptr + PW'(1);
         if (pop)  head_ptr <= head_ptr + PW'(1);
         if (push && !pop)      count <= count + CW'(1);
         else if (pop && !push) count <= count - CW'(1);
      end
   end

   // a store may land on a full queue only while the head leaves
   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full) |-> pop);

   p_no_underflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);

   p_full_swap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (push && pop && full) |=> full);

   p_count_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop) |=> (count == $past(count) + CW'(1)));

endmodule

// File: rtl/stbuf_search.sv
module stbuf_search #(
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int DEPTH = 4,
   localparam int BW   = DW / 8,
   localparam int PW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic [AW-1:0] ent_addr [DEPTH],
   input  logic [DW-1:0] ent_data [DEPTH],
   input  logic [BW-1:0] ent_be   [DEPTH],
   input  logic [PW-1:0] head_ptr,
   input  logic [CW-1:0] count,
   input  logic [AW-1:0] look_addr,
   output logic          hit,
   output logic          hit_full,
   output logic [DW-1:0] hit_data
);

   logic [DEPTH-1:0] slot_match;

   // match vector in age order: bit k is the k-th oldest entry
   always_comb begin
      for (int k = 0; k < DEPTH; k++) begin
         slot_match[k] = (CW'(k) < count) &&
                         (ent_addr[PW'(head_ptr + PW'(k))] == look_addr);
      end
   end

   // walk oldest to youngest, the last match wins
   always_comb begin
      hit      = 1'b0;
      hit_full = 1'b0;
      hit_data = '0;
      for (int k = 0; k < DEPTH; k++) begin
         if (slot_match[k]) begin
            hit      = 1'b1;
            hit_full = &ent_be[PW'(head_ptr + PW'(k))];
            hit_data = ent_data[PW'(head_ptr + PW'(k))];
         end
      end
   end

endmodule

// File: rtl/stbuf_rdctl.sv
module stbuf_rdctl
   import stbuf_pkg::*;
#(
   parameter int DW        = 32,
   parameter bit DRAIN_ALL = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_valid,
   input  logic          hit,
   input  logic          hit_full,
   input  logic [DW-1:0] hit_data,
   input  logic          q_empty,
   input  logic          mr_ready,
   input  logic [DW-1:0] mr_data,
   output logic          mr_valid,
   output logic          rd_done,
   output logic          rd_from_buf,
   output logic [DW-1:0] rd_data
);

   rd_route_e route;

   generate
      if (DRAIN_ALL) begin : g_drain
         always_comb begin
            if (!rd_valid)    route = RT_IDLE;
            else if (q_empty) route = RT_MEM;
            else              route = RT_HOLD;
         end

         p_drain_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
            mr_valid |-> q_empty);
      end else begin : g_fwd
         always_comb begin
            if (!rd_valid)            route = RT_IDLE;
            else if (!hit)            route = RT_MEM;
            else if (hit_full)        route = RT_FWD;
            else                      route = RT_HOLD;
         end

         p_partial_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_valid && hit && !hit_full) |-> (!rd_done && !mr_valid));

         p_miss_issue_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_valid && !hit) |-> mr_valid);
      end
   endgenerate

   assign mr_valid    = (route == RT_MEM);
   assign rd_from_buf = (route == RT_FWD);
   assign rd_done     = rd_from_buf || (mr_valid && mr_ready);
   assign rd_data     = rd_from_buf ? hit_data : mr_data;

   p_fwd_no_mem_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_from_buf |-> !mr_valid);

endmodule

// File: rtl/stbuf_fwd.sv
module stbuf_fwd #(
   parameter int AW        = 32,
   parameter int DW        = 32,
   parameter int DEPTH     = 4,
   parameter bit DRAIN_ALL = 1'b0,
   localparam int BW       = DW / 8,
   localparam int PW       = $clog2(DEPTH),
   localparam int CW       = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          st_valid,
   input  logic [AW-1:0] st_addr,
   input  logic [DW-1:0] st_data,
   input  logic [BW-1:0] st_be,
   output logic          cpu_stall,
   output logic          full,
   output logic          empty,
   output logic          mw_valid,
   output logic [AW-1:0] mw_addr,
   output logic [DW-1:0] mw_data,
   output logic [BW-1:0] mw_be,
   input  logic          mw_ready,
   input  logic          rd_valid,
   input  logic [AW-1:0] rd_addr,
   output logic          rd_done,
   output logic          rd_from_buf,
   output logic [DW-1:0] rd_data,
   output logic          mr_valid,
   output logic [AW-1:0] mr_addr,
   input  logic          mr_ready,
   input  logic [DW-1:0] mr_data
);

   initial begin
      a_depth_pow2: assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("DEPTH must be a power of two, at least 2");
      a_dw_bytes: assert (DW >= 8 && DW % 8 == 0)
         else $error("DW must be a whole number of bytes");
      a_aw_pos: assert (AW >= 1)
         else $error("AW must be positive");
   end

   logic [AW-1:0] ent_addr [DEPTH];
   logic [DW-1:0] ent_data [DEPTH];
   logic [BW-1:0] ent_be   [DEPTH];
   logic [PW-1:0] head_ptr;
   logic [CW-1:0] count;
   logic          push, pop;
   logic          hit, hit_full;
   logic [DW-1:0] hit_data;

   assign pop       = !empty && mw_ready;
   assign push      = st_valid && (!full || pop);
   assign cpu_stall = st_valid && !push;

   stbuf_queue #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_queue (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .push_addr (st_addr),
      .push_data (st_data),
      .push_be   (st_be),
      .pop       (pop),
      .ent_addr  (ent_addr),
      .ent_data  (ent_data),
      .ent_be    (ent_be),
      .head_ptr  (head_ptr),
      .count     (count),
      .full      (full),
      .empty     (empty)
   );

   assign mw_valid = !empty;
   assign mw_addr  = ent_addr[head_ptr];
   assign mw_data  = ent_data[head_ptr];
   assign mw_be    = ent_be[head_ptr];

   stbuf_search #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_search (
      .ent_addr  (ent_addr),
      .ent_data  (ent_data),
      .ent_be    (ent_be),
      .head_ptr  (head_ptr),
      .count     (count),
      .look_addr (rd_addr),
      .hit       (hit),
      .hit_full  (hit_full),
      .hit_data  (hit_data)
   );

   stbuf_rdctl #(.DW(DW), .DRAIN_ALL(DRAIN_ALL)) u_rdctl (
      .clk         (clk),
      .rst_n       (rst_n),
      .rd_valid    (rd_valid),
      .hit         (hit),
      .hit_full    (hit_full),
      .hit_data    (hit_data),
      .q_empty     (empty),
      .mr_ready    (mr_ready),
      .mr_data     (mr_data),
      .mr_valid    (mr_valid),
      .rd_done     (rd_done),
      .rd_from_buf (rd_from_buf),
      .rd_data     (rd_data)
   );

   assign mr_addr = rd_addr;

   p_stall_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_stall |-> (full && !mw_ready));

   p_head_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mw_valid && !mw_ready) |=> (mw_valid && $stable(mw_addr) &&
                                   $stable(mw_data) && $stable(mw_be)));

endmodule

// File: tb/stbuf_fwd_tb.sv
module stbuf_fwd_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int AW    = 3;
   localparam int DW    = 32;
   localparam int BW    = DW / 8;
   localparam int DEPTH = 4;
   localparam int WORDS = 1 << AW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   logic          st_valid = 1'b0;
   logic [AW-1:0] st_addr = '0;
   logic [DW-1:0] st_data = '0;
   logic [BW-1:0] st_be = '0;
   logic          mw_ready = 1'b0;
   logic          rd_valid = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic          mr_ready = 1'b0;
   logic [DW-1:0] mr_data, d_mr_data;

   logic          cpu_stall, full, empty, mw_valid, rd_done, rd_from_buf, mr_valid;
   logic [AW-1:0] mw_addr, mr_addr;
   logic [DW-1:0] mw_data, rd_data;
   logic [BW-1:0] mw_be;

   logic          d_cpu_stall, d_full, d_empty, d_mw_valid, d_rd_done, d_rd_from_buf, d_mr_valid;
   logic [AW-1:0] d_mw_addr, d_mr_addr;
   logic [DW-1:0] d_mw_data, d_rd_data;
   logic [BW-1:0] d_mw_be;

   // bench memory and queue model
   logic [DW-1:0] mem [WORDS];
   logic [AW-1:0] qa [DEPTH];
   logic [DW-1:0] qd [DEPTH];
   logic [BW-1:0] qb [DEPTH];
   int cnt = 0;
   int n_chk = 0;
   int n_fail = 0;

   assign mr_data   = mem[mr_addr];
   assign d_mr_data = mem[d_mr_addr];

   stbuf_fwd #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .DRAIN_ALL(1'b0)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
      .cpu_stall(cpu_stall), .full(full), .empty(empty),
      .mw_valid(mw_valid), .mw_addr(mw_addr), .mw_data(mw_data), .mw_be(mw_be),
      .mw_ready(mw_ready),
      .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_done(rd_done),
      .rd_from_buf(rd_from_buf), .rd_data(rd_data),
      .mr_valid(mr_valid), .mr_addr(mr_addr), .mr_ready(mr_ready), .mr_data(mr_data)
   );

   stbuf_fwd #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .DRAIN_ALL(1'b1)) dut_drain_i (
      .clk(clk), .rst_n(rst_n),
      .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
      .cpu_stall(d_cpu_stall), .full(d_full), .empty(d_empty),
      .mw_valid(d_mw_valid), .mw_addr(d_mw_addr), .mw_data(d_mw_data), .mw_be(d_mw_be),
      .mw_ready(mw_ready),
      .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_done(d_rd_done),
      .rd_from_buf(d_rd_from_buf), .rd_data(d_rd_data),
      .mr_valid(d_mr_valid), .mr_addr(d_mr_addr), .mr_ready(mr_ready), .mr_data(d_mr_data)
   );

   function automatic logic [DW-1:0] merge(logic [DW-1:0] v, logic [DW-1:0] d, logic [BW-1:0] be);
      for (int b = 0; b < BW; b++) if (be[b]) v[b*8 +: 8] = d[b*8 +: 8];
      return v;
   endfunction

   function automatic logic [DW-1:0] coherent(logic [AW-1:0] a);
      logic [DW-1:0] v = mem[a];
      for (int i = 0; i < cnt; i++) if (qa[i] == a) v = merge(v, qd[i], qb[i]);
      return v;
   endfunction

   function automatic int youngest(logic [AW-1:0] a);
      int j = -1;
      for (int i = 0; i < cnt; i++) if (qa[i] == a) j = i;
      return j;
   endfunction

   task automatic chk(input logic ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // check outputs at negedge, then commit the model after the edge
   task automatic run_cycle();
      logic do_push, do_pop;
      int j;
      @(negedge clk);
      do_pop  = (cnt > 0) && mw_ready;
      do_push = st_valid && (cnt < DEPTH || do_pop);
      chk(empty == (cnt == 0), "R3 empty", DW'(empty), DW'(cnt == 0));
      chk(full == (cnt == DEPTH), "R3 full", DW'(full), DW'(cnt == DEPTH));
      chk(cpu_stall == (st_valid && !do_push), "R3 cpu_stall", DW'(cpu_stall), DW'(st_valid && !do_push));
      chk(mw_valid == (cnt > 0), "R2 mw_valid", DW'(mw_valid), DW'(cnt > 0));
      if (cnt > 0) begin
         chk(mw_addr == qa[0], "R2 mw_addr", DW'(mw_addr), DW'(qa[0]));
         chk(mw_data == qd[0], "R2 mw_data", mw_data, qd[0]);
         chk(mw_be == qb[0], "R2 mw_be", DW'(mw_be), DW'(qb[0]));
      end
      chk(d_mr_valid == (rd_valid && cnt == 0), "R9 drain mr_valid", DW'(d_mr_valid), DW'(rd_valid && cnt == 0));
      chk(!d_rd_from_buf, "R9 drain no forward", DW'(d_rd_from_buf), '0);
      if (d_rd_done) chk(d_rd_data == coherent(rd_addr), "R10 drain data", d_rd_data, coherent(rd_addr));
      if (rd_valid) begin
         j = youngest(rd_addr);
         if (j >= 0 && &qb[j]) begin
            chk(rd_done && rd_from_buf && !mr_valid, "R5 forward route",
                {rd_done, rd_from_buf, mr_valid}, 3'b110);
            chk(rd_data == qd[j], "R6 youngest data", rd_data, qd[j]);
         end else if (j >= 0) begin
            chk(!rd_done && !mr_valid, "R8 partial wait", {rd_done, mr_valid}, '0);
         end else begin
            chk(mr_valid && mr_addr == rd_addr, "R7 miss issue", {mr_valid, DW'(mr_addr)}, {1'b1, DW'(rd_addr)});
            chk(rd_done == mr_ready, "R7 done on ready", DW'(rd_done), DW'(mr_ready));
         end
         if (rd_done) chk(rd_data == coherent(rd_addr), "R10 coherent data", rd_data, coherent(rd_addr));
      end else begin
         chk(!rd_done && !mr_valid, "R1 idle read", {rd_done, mr_valid}, '0);
      end
      @(posedge clk);
      #1;
      if (do_pop) begin
         mem[qa[0]] = merge(mem[qa[0]], qd[0], qb[0]);
         for (int i = 0; i < DEPTH - 1; i++) begin
            qa[i] = qa[i+1]; qd[i] = qd[i+1]; qb[i] = qb[i+1];
         end
         cnt--;
      end
      if (do_push) begin
         qa[cnt] = st_addr; qd[cnt] = st_data; qb[cnt] = st_be;
         cnt++;
      end
   endtask

   task automatic set_store(input logic v, input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [BW-1:0] be);
      st_valid = v; st_addr = a; st_data = d; st_be = be;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      for (int i = 0; i < WORDS; i++) mem[i] = 32'h0101_0101 * (i + 1);
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1: reset state
      @(negedge clk);
      chk(empty && !full && !mw_valid && !rd_done && !mr_valid, "R1 reset state",
          {empty, full, mw_valid, rd_done, mr_valid}, 5'b10000);
      @(posedge clk); #1;

      // R3/R4: fill with no drain, then push and drain together on full
      mw_ready = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
         set_store(1'b1, AW'(i), 32'hA000_0000 + i, '1);
         run_cycle();
      end
      set_store(1'b1, 3'd7, 32'hBEEF_0007, '1);
      run_cycle();
      chk(full, "R3 full holds with stall", DW'(full), 1);
      mw_ready = 1'b1;
      run_cycle();
      chk(full && cnt == DEPTH, "R4 full after push and pop", DW'(full), 1);
      set_store(1'b0, '0, '0, '0);
      repeat (DEPTH) run_cycle();
      mw_ready = 1'b0;

      // R6: two full stores to one address, read forwards the newer
      set_store(1'b1, 3'd5, 32'h1111_1111, '1); run_cycle();
      set_store(1'b1, 3'd5, 32'h2222_2222, '1); run_cycle();
      set_store(1'b0, '0, '0, '0);
      rd_valid = 1'b1; rd_addr = 3'd5; run_cycle();
      chk(rd_data == 32'h2222_2222, "R6 newer store wins", rd_data, 32'h2222_2222);
      // R7: unrelated address goes to memory despite occupancy
      rd_addr = 3'd1; mr_ready = 1'b1; run_cycle();
      rd_valid = 1'b0; mr_ready = 1'b0;
      // R8: partial store blocks the read until drained
      set_store(1'b1, 3'd2, 32'h0000_CAFE, 4'b0011); run_cycle();
      set_store(1'b0, '0, '0, '0);
      rd_valid = 1'b1; rd_addr = 3'd2; mr_ready = 1'b1;
      run_cycle();
      chk(!rd_done, "R8 read held on partial", DW'(rd_done), 0);
      mw_ready = 1'b1;
      for (int i = 0; i < 6 && rd_valid; i++) begin
         run_cycle();
         if (rd_done) rd_valid = 1'b0;
      end
      rd_valid = 1'b0;

      // random phase
      for (int c = 0; c < 4000; c++) begin
         set_store(($urandom % 2) == 0, AW'($urandom), $urandom,
                   (($urandom % 5) < 3) ? BW'('1) : BW'($urandom));
         mw_ready = ($urandom % 5) < 2;
         mr_ready = ($urandom % 5) < 3;
         if (!rd_valid && ($urandom % 5) < 2) begin
            rd_valid = 1'b1; rd_addr = AW'($urandom);
         end
         run_cycle();
         if (rd_done) rd_valid = 1'b0;
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule